// File: doc/BRIEF.md
# Element-Width Register Write Merge

This block sits in front of a 64-bit general register file and lets a vector of 8-, 16-, 32- or 64-bit elements be packed end to end across consecutive registers. A write names a base register, an element index and a width code. The block finds the register and the byte position that the element occupies. It then rewrites only those bytes and leaves every other bit of the register file as it was. A read port with the same addressing returns the chosen element, zero-extended to 64 bits.

Element 0 sits in the least significant bits of the base register. Higher elements follow it upward and carry on into the next register, so a vector of narrow elements can cover several registers. The storage is a flat array of `NUM_REGS` words: 32 for a small core, 128 for a large one. An element whose register falls past the last entry is flagged and has no effect.

Top module: `elw_regfile`

## Requirements
- R1: After reset every register holds zero, so any in-range read returns 0.
- R2: The width code is 2'b00 for 64 bits, 2'b01 for 32, 2'b10 for 16 and 2'b11 for 8. A write stores only that many low bits of `wr_data`.
- R3: With B bytes per element, an element lies in register base + (index*B)/8, at byte offset (index*B) mod 8 counted from the least significant byte. For example, with 16-bit elements at base 3, index 4 is the low 16 bits of register 4.
- R4: A write changes only the addressed element's bytes. All other bytes of the target register and all other registers keep their values. The new value can be read in the cycle after the clock edge that samples `wr_en`.
- R5: The read path is combinational. It returns the addressed element in the low bits of `rd_data` and zeros above it.
- R6: The same register bits read back consistently at every width. Four 16-bit elements written into one register read back as one 64-bit word with element 0 in bits 15:0, and each byte of that word reads back as an 8-bit element.
- R7: `wr_oor` is high combinationally when the write target register is at or beyond `NUM_REGS`. Such a write changes no register.
- R8: `rd_oor` is high when the read target register is at or beyond `NUM_REGS`. In that case `rd_data` is 0.
- R9: When a read and a write address the same element in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_base | input | $clog2(NUM_REGS) | Write base register |
| wr_idx | input | IDX_W | Write element index |
| wr_ew | input | 2 | Write width code |
| wr_data | input | 64 | Write element value, in the low bits |
| wr_oor | output | 1 | Write target is out of range |
| rd_base | input | $clog2(NUM_REGS) | Read base register |
| rd_idx | input | IDX_W | Read element index |
| rd_ew | input | 2 | Read width code |
| rd_data | output | 64 | Zero-extended element |
| rd_oor | output | 1 | Read target is out of range |

## Verification
The assertions check on every cycle that:
- the number of enabled byte lanes matches the width code;
- bytes outside the write mask keep their previous value;
- an out-of-range write leaves the whole array unchanged;
- read data carries nothing above the element width, and is zero when the read is out of range.

Only the bench scenarios can show the rest. These cover the exact register and offset arithmetic, the spill of a fifth 16-bit element into the next register, consistency between views at different widths, and read-before-write ordering in a shared cycle. Each of these is checked against a bench model of the packed layout.

// File: rtl/elw_pkg.sv
package elw_pkg;
    localparam int WORD_W     = 64;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        EW_64 = 2'b00,
        EW_32 = 2'b01,
        EW_16 = 2'b10,
        EW_8  = 2'b11
    } ew_t;

    // log2 of the element size in bytes
    function automatic logic [1:0] ew_log2_bytes(ew_t e);
        return 2'd3 - e;
    endfunction
endpackage

// File: rtl/elw_locate.sv
module elw_locate #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 8
) (
    input  logic [$clog2(NUM_REGS)-1:0] base,
    input  logic [IDX_W-1:0]            idx,
    input  elw_pkg::ew_t                ew,
    output logic [$clog2(NUM_REGS)-1:0] reg_sel,
    output logic [2:0]                  byte_off,
    output logic                        oor
);
    localparam int RAW   = $clog2(NUM_REGS);
    localparam int POS_W = IDX_W + 3;
    localparam int SUM_W = IDX_W + RAW + 1;

    logic [POS_W-1:0] byte_pos;
    logic [SUM_W-1:0] full_reg;

    always_comb begin
        byte_pos = POS_W'(idx) << elw_pkg::ew_log2_bytes(ew);
        full_reg = SUM_W'(base) + SUM_W'(byte_pos[POS_W-1:3]);
        reg_sel  = full_reg[RAW-1:0];
        byte_off = byte_pos[2:0];
        oor      = (full_reg >= SUM_W'(NUM_REGS));
    end
endmodule

// File: rtl/elw_lane_mask.sv
module elw_lane_mask (
    input  elw_pkg::ew_t  ew,
    input  logic [2:0]    byte_off,
    output logic [7:0]    byte_en,
    output logic [63:0]   bit_mask
);
    logic [7:0] base_en;

    always_comb begin
        unique case (ew)
            elw_pkg::EW_64: base_en = 8'hFF;
            elw_pkg::EW_32: base_en = 8'h0F;
            elw_pkg::EW_16: base_en = 8'h03;
            default:        base_en = 8'h01;
        endcase
        byte_en = base_en << byte_off;
    end

    for (genvar b = 0; b < elw_pkg::WORD_BYTES; b++) begin : g_lane
        assign bit_mask[8*b +: 8] = {8{byte_en[b]}};
    end
endmodule

// File: rtl/elw_merge.sv
module elw_merge (
    input  logic [63:0] old_word,
    input  logic [63:0] elem,
    input  logic [2:0]  byte_off,
    input  logic [63:0] bit_mask,
    output logic [63:0] new_word
);
    logic [63:0] placed;

    always_comb begin
        placed   = elem << {byte_off, 3'b000};
        new_word = (old_word & ~bit_mask) | (placed & bit_mask);
    end
endmodule

// File: rtl/elw_extract.sv
module elw_extract (
    input  logic [63:0] word,
    input  logic [2:0]  byte_off,
    input  logic [63:0] bit_mask,
    output logic [63:0] elem
);
    always_comb begin
        elem = (word & bit_mask) >> {byte_off, 3'b000};
    end
endmodule

// File: rtl/elw_regfile.sv
module elw_regfile #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_base,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [1:0]                  wr_ew,
    input  logic [63:0]                 wr_data,
    output logic                        wr_oor,
    input  logic [$clog2(NUM_REGS)-1:0] rd_base,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [1:0]                  rd_ew,
    output logic [63:0]                 rd_data,
    output logic                        rd_oor
);
    localparam int RAW = $clog2(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][63:0] rf;
    } state_t;

    state_t state_d, state_q;

    elw_pkg::ew_t     w_ew, r_ew;
    logic [RAW-1:0]   w_reg, r_reg;
    logic [2:0]       w_off, r_off;
    logic [7:0]       w_byte_en, r_byte_en;
    logic [63:0]      w_bits, r_bits;
    logic [63:0]      w_merged, r_elem;

    assign w_ew = elw_pkg::ew_t'(wr_ew);
    assign r_ew = elw_pkg::ew_t'(rd_ew);

    // write path
    elw_locate #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wloc (
        .base(wr_base), .idx(wr_idx), .ew(w_ew),
        .reg_sel(w_reg), .byte_off(w_off), .oor(wr_oor)
    );
    elw_lane_mask u_wmask (
        .ew(w_ew), .byte_off(w_off), .byte_en(w_byte_en), .bit_mask(w_bits)
    );
    elw_merge u_merge (
        .old_word(state_q.rf[w_reg]), .elem(wr_data), .byte_off(w_off),
        .bit_mask(w_bits), .new_word(w_merged)
    );

    // read path
    elw_locate #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rloc (
        .base(rd_base), .idx(rd_idx), .ew(r_ew),
        .reg_sel(r_reg), .byte_off(r_off), .oor(rd_oor)
    );
    elw_lane_mask u_rmask (
        .ew(r_ew), .byte_off(r_off), .byte_en(r_byte_en), .bit_mask(r_bits)
    );
    elw_extract u_extract (
        .word(state_q.rf[r_reg]), .byte_off(r_off), .bit_mask(r_bits),
        .elem(r_elem)
    );

    assign rd_data = rd_oor ? 64'd0 : r_elem;

    always_comb begin
        state_d = state_q;
        if (wr_en && !wr_oor) begin
            state_d.rf[w_reg] = w_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // enabled lane count follows the width code
    p_lane_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(w_byte_en) == (32'd1 << elw_pkg::ew_log2_bytes(w_ew)));

    // bytes outside the mask are untouched by an accepted write
    p_neighbours_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_oor) |=>
        ((state_q.rf[$past(w_reg)] & ~$past(w_bits)) ==
         ($past(state_q.rf[w_reg]) & ~$past(w_bits))));

    // an out-of-range write leaves the array as it was
    p_oor_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_oor) |=> $stable(state_q));

    // nothing above the element width on the read port
    p_zero_extend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ew != elw_pkg::EW_64) |->
        ((rd_data >> (32'd8 << elw_pkg::ew_log2_bytes(r_ew))) == 64'd0));

    // an out-of-range read yields zero
    p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oor |-> (rd_data == 64'd0));
endmodule

// File: tb/elw_regfile_tb.sv
module elw_regfile_tb;
    localparam int NUM_REGS = 32;
    localparam int IDX_W    = 8;
    localparam int RAW      = $clog2(NUM_REGS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [RAW-1:0]   wr_base = '0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [1:0]       wr_ew = '0;
    logic [63:0]      wr_data = '0;
    logic             wr_oor;
    logic [RAW-1:0]   rd_base = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [1:0]       rd_ew = '0;
    logic [63:0]      rd_data;
    logic             rd_oor;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc   = 0;
    bit          done  = 1'b0;
    logic [63:0] model [NUM_REGS];

    always #5 clk = ~clk;

    elw_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_base(wr_base),
        .wr_idx(wr_idx), .wr_ew(wr_ew), .wr_data(wr_data), .wr_oor(wr_oor),
        .rd_base(rd_base), .rd_idx(rd_idx), .rd_ew(rd_ew),
        .rd_data(rd_data), .rd_oor(rd_oor)
    );

    function automatic int nbytes(logic [1:0] ew);
        case (ew)
            2'b00: return 8;
            2'b01: return 4;
            2'b10: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int tgt_reg(int base, int idx, logic [1:0] ew);
        return base + (idx * nbytes(ew)) / 8;
    endfunction

    function automatic int tgt_off(int idx, logic [1:0] ew);
        return (idx * nbytes(ew)) % 8;
    endfunction

    function automatic logic [63:0] wmask(logic [1:0] ew);
        return (nbytes(ew) == 8) ? 64'hFFFF_FFFF_FFFF_FFFF
                                 : ((64'd1 << (8 * nbytes(ew))) - 64'd1);
    endfunction

    function automatic logic [63:0] exp_read(int base, int idx, logic [1:0] ew);
        int r;
        r = tgt_reg(base, idx, ew);
        if (r >= NUM_REGS) return 64'd0;
        return (model[r] >> (8 * tgt_off(idx, ew))) & wmask(ew);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check combinational outputs, commit at posedge
    task automatic op(string req, bit we, int wb, int wi, logic [1:0] wew,
                      logic [63:0] wd, int rb, int ri, logic [1:0] rew);
        int r;
        int o;
        @(negedge clk);
        wr_en = we; wr_base = RAW'(wb); wr_idx = IDX_W'(wi);
        wr_ew = wew; wr_data = wd;
        rd_base = RAW'(rb); rd_idx = IDX_W'(ri); rd_ew = rew;
        #1;
        check({req, " rd_data"}, rd_data, exp_read(rb, ri, rew));
        check("R8 rd_oor", 64'(rd_oor), 64'(tgt_reg(rb, ri, rew) >= NUM_REGS));
        check("R7 wr_oor", 64'(wr_oor), 64'(tgt_reg(wb, wi, wew) >= NUM_REGS));
        @(posedge clk);
        r = tgt_reg(wb, wi, wew);
        o = tgt_off(wi, wew);
        if (we && r < NUM_REGS) begin
            model[r] = (model[r] & ~(wmask(wew) << (8 * o))) |
                       ((wd & wmask(wew)) << (8 * o));
        end
    endtask

    task automatic rd_only(string req, int rb, int ri, logic [1:0] rew,
                           logic [63:0] exp);
        @(negedge clk);
        wr_en = 1'b0; rd_base = RAW'(rb); rd_idx = IDX_W'(ri); rd_ew = rew;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NUM_REGS; i++) model[i] = 64'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        rd_only("R1 reset r0", 0, 0, 2'b00, 64'd0);
        rd_only("R1 reset r31", 31, 0, 2'b00, 64'd0);

        // R3/R4: fifth 16-bit element spills into next register's low lane
        op("R4 prefill", 1, 4, 0, 2'b00, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, 2'b00);
        op("R3 e0", 1, 3, 0, 2'b10, 64'hFFFF_FFFF_FFFF_1111, 0, 0, 2'b00);
        op("R3 e1", 1, 3, 1, 2'b10, 64'h2222, 0, 0, 2'b00);
        op("R3 e2", 1, 3, 2, 2'b10, 64'h3333, 0, 0, 2'b00);
        op("R3 e3", 1, 3, 3, 2'b10, 64'h4444, 0, 0, 2'b00);
        op("R3 e4", 1, 3, 4, 2'b10, 64'h1234, 0, 0, 2'b00);
        rd_only("R3 spill reg4", 4, 0, 2'b00, 64'hAAAA_AAAA_AAAA_1234);
        rd_only("R2 only low 16 stored", 3, 0, 2'b10, 64'h1111);
        // R6: cross-width views of register 3
        rd_only("R6 64-bit view", 3, 0, 2'b00, 64'h4444_3333_2222_1111);
        rd_only("R6 8-bit view byte2", 3, 2, 2'b11, 64'h22);
        rd_only("R6 32-bit view hi", 3, 1, 2'b01, 64'h4444_3333);
        rd_only("R5 zero-extend 8-bit", 4, 7, 2'b11, 64'hAA);

        // R7: out-of-range write ignored, R8: out-of-range read
        op("R7 oor write", 1, 31, 8, 2'b11, 64'hFF, 31, 0, 2'b00);
        rd_only("R7 r31 unchanged", 31, 0, 2'b00, 64'd0);
        rd_only("R8 oor read", 30, 4, 2'b01, 64'd0);

        // R9: same-cycle read sees old value
        op("R9 same element", 1, 4, 0, 2'b10, 64'h5678, 4, 0, 2'b10);
        rd_only("R9 new value after edge", 4, 0, 2'b10, 64'h5678);

        // random mix (R2 R3 R4 R5)
        for (int k = 0; k < 2000; k++) begin
            op("R3/R4 random", ($urandom % 4) != 0, $urandom % NUM_REGS,
               $urandom % 64, 2'($urandom), {$urandom, $urandom},
               $urandom % NUM_REGS, $urandom % 64, 2'($urandom));
        end
        // sweep every register at full width to catch stray writes (R4)
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_only("R4 final sweep", i, 0, 2'b00, model[i]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule